// File: doc/BRIEF.md
# Block-Cipher Job Register Front-End

This block is the 32-bit memory-mapped register file that sits in front of a block-cipher DMA engine. Software programs one job through it: the source and destination addresses, the byte count, the operating options, a 128-bit key and a 128-bit chaining value. It then sets the start bit. The block turns that write into a single-cycle start pulse toward a downstream sequencer and holds a busy flag until the sequencer reports completion. The completion event is latched as a pending flag in the interrupt register. Software polls that flag or takes the masked interrupt output. The pending flags are cleared by writing ones to them.

The cipher datapath and the bus master are not part of this block. They appear only as a done input, a second-channel done input and a final chaining value that is loaded back when a chained job finishes. Software can read the chaining value words and seed the next job of a chain with them. The key words cannot be read back.

Top module: `cipher_ctl_regs`

## Requirements
- R1: After synchronous reset every readable register reads zero, and `irq`, `job_start` and `job_busy` are low.
- R2: Offsets 0x10, 0x14 and 0x18 hold the source address, destination address and byte length. Each reads back the last written value and drives `job_src`, `job_dst` and `job_len`.
- R3: Control register offset 0x00 has these bits. Bit 1 selects encrypt (1) or decrypt (0). Bit 2 selects the user-written key. Bit 3 is the destination coherency hint. Bit 4 is the source coherency hint. Bit 5 selects chained mode. Bits 5:1 read back and drive `job_encrypt`, `job_usr_key`, `job_coh_dst`, `job_coh_src` and `job_chain`. Bits 31:6 read zero.
- R4: A control write with bit 0 set while idle raises `job_start` for exactly the one cycle after the write. Bit 0 reads 1 in that cycle only. `job_busy` goes high with the pulse.
- R5: While `job_busy` is high, a control write is ignored entirely: there is no pulse and the option bits do not change.
- R6: `job_done` while busy clears `job_busy` and sets pending bit 16 of offset 0x08. `job_done` while idle has no effect. `chb_done` sets pending bit 17.
- R7: At offset 0x08, writing 1 to bit 16 or 17 clears that pending bit and writing 0 leaves it. A completion event in the same cycle as the clear wins, so the bit stays set. Bits 2:0 are mask bits that take the written value. Bits 7:3 read zero.
- R8: `irq` is high exactly when pending bit 16 is set with mask bit 0 set, or pending bit 17 is set with mask bit 1 set. Mask bit 2 is only stored.
- R9: The key is written as four words at 0x30, 0x34, 0x38 and 0x3C. The word at 0x30 holds key bits 31:0, and higher offsets hold higher bits. The key drives `job_key`, and reads of the key words return zero.
- R10: The chaining value is written as four words at 0x40 to 0x4C in the same word order as the key. It drives `job_iv` and reads back.
- R11: When a job completes with chained mode set, the chaining value is replaced by `iv_final`. When a job completes without chained mode, the chaining value is unchanged.
- R12: Any other byte address reads zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| job_start | output | 1 | One-cycle start pulse to the sequencer |
| job_busy | output | 1 | Job in flight |
| job_src | output | 32 | Source address |
| job_dst | output | 32 | Destination address |
| job_len | output | 32 | Byte length |
| job_encrypt | output | 1 | 1 = encrypt, 0 = decrypt |
| job_usr_key | output | 1 | Use the written key |
| job_coh_dst | output | 1 | Destination coherency hint |
| job_coh_src | output | 1 | Source coherency hint |
| job_chain | output | 1 | Chained mode |
| job_key | output | 128 | Key |
| job_iv | output | 128 | Chaining value |
| job_done | input | 1 | Sequencer completion, channel A |
| iv_final | input | 128 | Final chaining value from the sequencer |
| chb_done | input | 1 | Completion event, channel B |
| irq | output | 1 | Masked interrupt |

## Verification
The checker watches properties on every cycle. The start pulse is never longer than one cycle. Busy only begins with a pulse. A busy period without a done never lets a new pulse through. Done always ends busy. `irq` cannot move without a bus write or a completion event. The chaining value cannot move without a write or a completion. The bench scenarios are the only way to show the encodings: the bit positions of the options and flags, the write-one-to-clear rule, the set-wins collision, the key being hidden on reads, the chaining value loaded back, and the silence of undefined offsets. They do this with sweeps over every control value, every mask and pending combination, and every byte address.

// File: rtl/cipher_ctl_pkg.sv
package cipher_ctl_pkg;

    localparam int unsigned REG_W      = 32;
    localparam int unsigned ADDR_W     = 8;
    localparam int unsigned WIDE_WORDS = 4;
    localparam int unsigned WIDE_W     = WIDE_WORDS * REG_W;
    localparam int unsigned IRQ_CH     = 2;
    localparam int unsigned MASK_W     = 3;
    localparam int unsigned PEND_LSB   = 16;
    localparam int unsigned CFG_LSB    = 1;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_INTR = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_SRC  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_DST  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_LEN  = 8'h18;
    localparam logic [3:0]        KEY_PAGE = 4'h3;
    localparam logic [3:0]        IV_PAGE  = 4'h4;

    // Packs onto control bits 5:1, most significant field first.
    typedef struct packed {
        logic chain;
        logic coh_src;
        logic coh_dst;
        logic usr_key;
        logic encrypt;
    } job_cfg_t;

    localparam int unsigned CFG_W = $bits(job_cfg_t);

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_INTR,
        SEL_SRC,
        SEL_DST,
        SEL_LEN,
        SEL_KEY,
        SEL_IV
    } reg_sel_e;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        s = SEL_NONE;
        if (a == OFS_CTRL)      s = SEL_CTRL;
        else if (a == OFS_INTR) s = SEL_INTR;
        else if (a == OFS_SRC)  s = SEL_SRC;
        else if (a == OFS_DST)  s = SEL_DST;
        else if (a == OFS_LEN)  s = SEL_LEN;
        else if (a[1:0] == 2'b00 && a[7:4] == KEY_PAGE) s = SEL_KEY;
        else if (a[1:0] == 2'b00 && a[7:4] == IV_PAGE)  s = SEL_IV;
        return s;
    endfunction

    function automatic logic [1:0] word_of(input logic [ADDR_W-1:0] a);
        return a[3:2];
    endfunction

endpackage

// File: rtl/cipher_ctl_wide_field.sv
module cipher_ctl_wide_field
    import cipher_ctl_pkg::*;
#(
    parameter int unsigned WORDS    = 4,
    parameter bit          READABLE = 1'b1,
    parameter int unsigned IDX_W    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [REG_W-1:0]         wr_data,
    input  logic                     load_en,
    input  logic [WORDS*REG_W-1:0]   load_val,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic [WORDS*REG_W-1:0]   value,
    output logic [REG_W-1:0]         rd_data
);

    logic [REG_W-1:0] word_q [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q[w] <= '0;
            end else if (load_en) begin
                word_q[w] <= load_val[w*REG_W +: REG_W];
            end else if (wr_en && wr_idx == IDX_W'(w)) begin
                word_q[w] <= wr_data;
            end
        end
        assign value[w*REG_W +: REG_W] = word_q[w];
    end

    if (READABLE) begin : g_rd
        always_comb begin
            rd_data = '0;
            for (int w = 0; w < WORDS; w++) begin
                if (rd_idx == IDX_W'(w)) rd_data = word_q[w];
            end
        end
    end else begin : g_hidden
        logic unused_idx;
        assign unused_idx = ^rd_idx;
        assign rd_data    = '0;
    end

endmodule

// File: rtl/cipher_ctl_job.sv
module cipher_ctl_job
    import cipher_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_wr,
    input  logic             wr_start,
    input  job_cfg_t         wr_cfg,
    input  logic             seq_done,
    output logic             start_q,
    output logic             busy_q,
    output job_cfg_t         cfg_q,
    output logic             done_evt
);

    logic accept;

    assign accept   = ctrl_wr && !busy_q;
    assign done_evt = busy_q && seq_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= 1'b0;
            busy_q  <= 1'b0;
            cfg_q   <= '0;
        end else begin
            start_q <= accept && wr_start;
            if (accept) begin
                cfg_q <= wr_cfg;
            end
            if (accept && wr_start) begin
                busy_q <= 1'b1;
            end else if (done_evt) begin
                busy_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cipher_ctl_irq.sv
module cipher_ctl_irq
    import cipher_ctl_pkg::*;
#(
    parameter int unsigned CH    = IRQ_CH,
    parameter int unsigned MSK_W = MASK_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             intr_wr,
    input  logic [CH-1:0]    clr_bits,
    input  logic [MSK_W-1:0] mask_in,
    input  logic [CH-1:0]    evt,
    output logic [CH-1:0]    pend_q,
    output logic [MSK_W-1:0] mask_q,
    output logic             irq
);

    logic [CH-1:0] hit;

    for (genvar c = 0; c < CH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q[c] <= 1'b0;
            end else if (evt[c]) begin
                pend_q[c] <= 1'b1;
            end else if (intr_wr && clr_bits[c]) begin
                pend_q[c] <= 1'b0;
            end
        end
        assign hit[c] = pend_q[c] & mask_q[c];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (intr_wr) begin
            mask_q <= mask_in;
        end
    end

    assign irq = |hit;

endmodule

// File: rtl/cipher_ctl_regs.sv
module cipher_ctl_regs
    import cipher_ctl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     bus_rdata,
    output logic                 job_start,
    output logic                 job_busy,
    output logic [REG_W-1:0]     job_src,
    output logic [REG_W-1:0]     job_dst,
    output logic [REG_W-1:0]     job_len,
    output logic                 job_encrypt,
    output logic                 job_usr_key,
    output logic                 job_coh_dst,
    output logic                 job_coh_src,
    output logic                 job_chain,
    output logic [WIDE_W-1:0]    job_key,
    output logic [WIDE_W-1:0]    job_iv,
    input  logic                 job_done,
    input  logic [WIDE_W-1:0]    iv_final,
    input  logic                 chb_done,
    output logic                 irq
);

    reg_sel_e          sel;
    logic              wr_ctrl, wr_intr, wr_key, wr_iv;
    logic [1:0]        widx;
    job_cfg_t          cfg_q;
    logic              start_q, busy_q, done_evt;
    logic [IRQ_CH-1:0] pend_q;
    logic [MASK_W-1:0] mask_q;
    logic [REG_W-1:0]  src_q, dst_q, len_q;
    logic [REG_W-1:0]  key_rd, iv_rd;

    assign sel     = decode_sel(bus_addr);
    assign widx    = word_of(bus_addr);
    assign wr_ctrl = bus_wr && (sel == SEL_CTRL);
    assign wr_intr = bus_wr && (sel == SEL_INTR);
    assign wr_key  = bus_wr && (sel == SEL_KEY);
    assign wr_iv   = bus_wr && (sel == SEL_IV);

    cipher_ctl_job u_job (
        .clk      (clk),
        .rst      (rst),
        .ctrl_wr  (wr_ctrl),
        .wr_start (bus_wdata[0]),
        .wr_cfg   (job_cfg_t'(bus_wdata[CFG_LSB +: CFG_W])),
        .seq_done (job_done),
        .start_q  (start_q),
        .busy_q   (busy_q),
        .cfg_q    (cfg_q),
        .done_evt (done_evt)
    );

    cipher_ctl_irq #(.CH(IRQ_CH), .MSK_W(MASK_W)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .intr_wr  (wr_intr),
        .clr_bits (bus_wdata[PEND_LSB +: IRQ_CH]),
        .mask_in  (bus_wdata[MASK_W-1:0]),
        .evt      ({chb_done, done_evt}),
        .pend_q   (pend_q),
        .mask_q   (mask_q),
        .irq      (irq)
    );

    cipher_ctl_wide_field #(.WORDS(WIDE_WORDS), .READABLE(1'b0)) u_key (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_key),
        .wr_idx   (widx),
        .wr_data  (bus_wdata),
        .load_en  (1'b0),
        .load_val ('0),
        .rd_idx   (widx),
        .value    (job_key),
        .rd_data  (key_rd)
    );

    cipher_ctl_wide_field #(.WORDS(WIDE_WORDS), .READABLE(1'b1)) u_iv (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_iv),
        .wr_idx   (widx),
        .wr_data  (bus_wdata),
        .load_en  (done_evt && cfg_q.chain),
        .load_val (iv_final),
        .rd_idx   (widx),
        .value    (job_iv),
        .rd_data  (iv_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= '0;
            dst_q <= '0;
            len_q <= '0;
        end else if (bus_wr) begin
            if (sel == SEL_SRC) src_q <= bus_wdata;
            if (sel == SEL_DST) dst_q <= bus_wdata;
            if (sel == SEL_LEN) len_q <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (sel)
                SEL_CTRL: begin
                    bus_rdata[0]                = start_q;
                    bus_rdata[CFG_LSB +: CFG_W] = cfg_q;
                end
                SEL_INTR: begin
                    bus_rdata[PEND_LSB +: IRQ_CH] = pend_q;
                    bus_rdata[MASK_W-1:0]         = mask_q;
                end
                SEL_SRC:  bus_rdata = src_q;
                SEL_DST:  bus_rdata = dst_q;
                SEL_LEN:  bus_rdata = len_q;
                SEL_KEY:  bus_rdata = key_rd;
                SEL_IV:   bus_rdata = iv_rd;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign job_start   = start_q;
    assign job_busy    = busy_q;
    assign job_src     = src_q;
    assign job_dst     = dst_q;
    assign job_len     = len_q;
    assign job_encrypt = cfg_q.encrypt;
    assign job_usr_key = cfg_q.usr_key;
    assign job_coh_dst = cfg_q.coh_dst;
    assign job_coh_src = cfg_q.coh_src;
    assign job_chain   = cfg_q.chain;

endmodule

// File: rtl/cipher_ctl_regs_chk.sv
module cipher_ctl_regs_chk
    import cipher_ctl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              job_start,
    input logic              job_busy,
    input logic              job_done,
    input logic              chb_done,
    input logic              irq,
    input logic [WIDE_W-1:0] job_iv
);

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        job_start |=> !job_start); // R4

    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst)
        $rose(job_busy) |-> job_start); // R4

    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (job_busy && !job_done) |=> !job_start); // R5

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (job_busy && job_done) |=> !job_busy); // R6

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr && !job_done && !chb_done) |=> $stable(irq)); // R8

    AST_IV_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr && !job_done) |=> $stable(job_iv)); // R11

endmodule

bind cipher_ctl_regs cipher_ctl_regs_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .job_start (job_start),
    .job_busy  (job_busy),
    .job_done  (job_done),
    .chb_done  (chb_done),
    .irq       (irq),
    .job_iv    (job_iv)
);

// File: tb/cipher_ctl_regs_test.sv
module cipher_ctl_regs_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         job_start, job_busy;
    logic [31:0]  job_src, job_dst, job_len;
    logic         job_encrypt, job_usr_key, job_coh_dst, job_coh_src, job_chain;
    logic [127:0] job_key, job_iv;
    logic         job_done = 1'b0;
    logic [127:0] iv_final = '0;
    logic         chb_done = 1'b0;
    logic         irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    cipher_ctl_regs uut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    task automatic pulse_done();
        @(negedge clk); job_done = 1'b1;
        @(negedge clk); job_done = 1'b0;
    endtask

    task automatic pulse_chb();
        @(negedge clk); chb_done = 1'b1;
        @(negedge clk); chb_done = 1'b0;
    endtask

    function automatic bit is_defined(input logic [7:0] a);
        if (a == 8'h00 || a == 8'h08 || a == 8'h10 || a == 8'h14 || a == 8'h18) return 1'b1;
        if (a[1:0] == 2'b00 && (a[7:4] == 4'h3 || a[7:4] == 4'h4)) return 1'b1;
        return 1'b0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [127:0] ivv, snap_iv;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd_chk("R1", 8'h00, 32'h0); rd_chk("R1", 8'h08, 32'h0);
        rd_chk("R1", 8'h10, 32'h0); rd_chk("R1", 8'h18, 32'h0);
        rd_chk("R1", 8'h40, 32'h0);
        check("R1", {29'b0, irq, job_start, job_busy}, 32'h0);

        // R2 pointer and length registers
        for (int i = 0; i < 4; i++) begin
            logic [31:0] p;
            p = 32'h1357_9BDF * (i + 1) ^ (32'hA5A5_0000 >> i);
            wr(8'h10, p); wr(8'h14, ~p); wr(8'h18, p + 32'd16);
            rd_chk("R2", 8'h10, p); rd_chk("R2", 8'h14, ~p); rd_chk("R2", 8'h18, p + 32'd16);
            check("R2", job_src, p); check("R2", job_dst, ~p); check("R2", job_len, p + 32'd16);
        end

        // R3 / R4 sweep over every control value
        for (int v = 0; v < 64; v++) begin
            logic [31:0] cv;
            cv = 32'(v) | 32'hFFFF_FFC0;
            wr(8'h00, cv);
            if (v[0]) begin
                check("R4", {30'b0, job_start, job_busy}, 32'h3);
                rd_chk("R4", 8'h00, 32'(v));
                @(negedge clk);
                check("R4", {30'b0, job_start, job_busy}, 32'h1);
                rd_chk("R3", 8'h00, 32'(v) & 32'h3E);
                check("R3", {27'b0, job_chain, job_coh_src, job_coh_dst, job_usr_key, job_encrypt},
                      32'(v >> 1));
                pulse_done();
                check("R6", {31'b0, job_busy}, 32'h0);
                wr(8'h08, 32'h0003_0000);
            end else begin
                check("R4", {30'b0, job_start, job_busy}, 32'h0);
                rd_chk("R3", 8'h00, 32'(v));
                check("R3", {27'b0, job_chain, job_coh_src, job_coh_dst, job_usr_key, job_encrypt},
                      32'(v >> 1));
            end
        end

        // R5 control write while busy is ignored
        wr(8'h00, 32'h03);
        @(negedge clk);
        wr(8'h00, 32'h3F);
        check("R5", {31'b0, job_start}, 32'h0);
        rd_chk("R5", 8'h00, 32'h02);
        check("R5", {31'b0, job_busy}, 32'h1);

        // R6 completion sets pending A; idle done ignored; channel B
        pulse_done();
        rd_chk("R6", 8'h08, 32'h0001_0000);
        wr(8'h08, 32'h0001_0000);
        pulse_done();
        rd_chk("R6", 8'h08, 32'h0);
        pulse_chb();
        rd_chk("R6", 8'h08, 32'h0002_0000);

        // R7 write-one-to-clear, mask write, set wins
        wr(8'h00, 32'h01); pulse_done();
        wr(8'h08, 32'h0002_00FD);
        rd_chk("R7", 8'h08, 32'h0001_0005);
        wr(8'h08, 32'h0000_0002);
        rd_chk("R7", 8'h08, 32'h0001_0002);
        wr(8'h08, 32'h0001_0000);
        wr(8'h00, 32'h01);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 32'h0001_0000; job_done = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; job_done = 1'b0;
        rd_chk("R7", 8'h08, 32'h0001_0000);

        // R8 every mask against every pending combination
        for (int m = 0; m < 8; m++) begin
            for (int pc = 0; pc < 4; pc++) begin
                wr(8'h08, 32'h0003_0000 | 32'(m));
                if (pc[0]) begin wr(8'h00, 32'h01); pulse_done(); end
                if (pc[1]) pulse_chb();
                check("R8", {31'b0, irq}, {31'b0, (pc[0] & m[0]) | (pc[1] & m[1])});
            end
        end
        wr(8'h08, 32'h0003_0000);

        // R9 key words, hidden on read
        for (int w = 0; w < 4; w++) wr(8'h30 + 8'(4*w), 32'hC0DE_0000 + 32'(w * 17));
        check("R9", job_key[31:0], 32'hC0DE_0000);
        check("R9", job_key[127:96], 32'hC0DE_0033);
        for (int w = 0; w < 4; w++) rd_chk("R9", 8'h30 + 8'(4*w), 32'h0);

        // R10 chaining value words
        for (int w = 0; w < 4; w++) wr(8'h40 + 8'(4*w), 32'h1A00_0000 + 32'(w));
        for (int w = 0; w < 4; w++) begin
            rd_chk("R10", 8'h40 + 8'(4*w), 32'h1A00_0000 + 32'(w));
            check("R10", job_iv[w*32 +: 32], 32'h1A00_0000 + 32'(w));
        end

        // R11 chained job loads final value, plain job does not
        ivv = {32'hDDDD_0003, 32'hCCCC_0002, 32'hBBBB_0001, 32'hAAAA_0000};
        iv_final = ivv;
        wr(8'h00, 32'h21); pulse_done();
        for (int w = 0; w < 4; w++) rd_chk("R11", 8'h40 + 8'(4*w), ivv[w*32 +: 32]);
        iv_final = ~ivv;
        wr(8'h00, 32'h01); pulse_done();
        for (int w = 0; w < 4; w++) rd_chk("R11", 8'h40 + 8'(4*w), ivv[w*32 +: 32]);
        wr(8'h08, 32'h0003_0000);

        // R12 every undefined byte address
        snap_iv = job_iv;
        for (int a = 0; a < 256; a++) begin
            if (!is_defined(8'(a))) begin
                rd(8'(a), d);
                check("R12", d, 32'h0);
                wr(8'(a), 32'hFFFF_FFFF);
            end
        end
        check("R12", {30'b0, job_start, job_busy}, 32'h0);
        rd_chk("R12", 8'h00, 32'h0);
        rd_chk("R12", 8'h08, 32'h0);
        check("R12", job_iv[31:0], snap_iv[31:0]);
        check("R12", job_iv[127:96], snap_iv[127:96]);
        check("R12", job_key[63:32], 32'hC0DE_0011);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule